// File: doc/BRIEF.md
# MDIO Management Master with Link Scan

This block is a master for the two-wire PHY management bus. It makes the management clock (MDC) from the system clock through an even divider that software sets. It runs single read or write frames to any PHY and register address. Software drives it through a small word-indexed register port: it writes the mode, address and data, then issues a command, polls the busy flag, and picks up the returned data.

Besides single accesses, the block has a scan command. Scan reads PHY register 1 over and over with no software involvement. Each completed scan read sets the link-fail flag to the inverse of the link-up bit. The 32-cycle preamble can be switched off to shorten every frame. MDIO output changes only on the falling MDC edge. Read data is sampled on the rising MDC edge.

Register index map on `reg_addr`:
- 0: mode. Bits 7:1 are the half-period and bit 0 always reads 0. Bit 8 suppresses the preamble.
- 1: command. Bit 0 is scan, bit 1 is read and bit 2 is write.
- 2: address. The PHY is in bits 4:0 and the register is in bits 12:8.
- 3: write data.
- 4: read data.
- 5: status. Bit 0 is link fail, bit 1 is busy and bit 2 is invalid.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the status, read data, mode and command registers all read 0. MDC is low and `mdio_oe` is low.
- R2: The MDC period equals the mode divider in system clocks. Bit 0 of the divider is ignored, and a divider below 2 acts as 2. MDC stays low whenever the block is not busy.
- R3: A write frame is sent MSB first as: 32 preamble ones, start `01`, opcode `01`, the 5-bit PHY address, the 5-bit register address, turnaround `10`, then 16 data bits. `mdio_oe` stays high for the whole frame.
- R4: A read frame sends start `01`, opcode `10`, the PHY address and the register address. From the first turnaround bit to the end of the frame, `mdio_oe` is low (a frame without preamble shows oe pattern 0xFFFC0000 over its 32 bits). The 16 data bits are sampled on the rising edges of MDC and land in the read data register.
- R5: With mode bit 8 set, the frame starts directly with the start bits and has exactly 32 MDC cycles.
- R6: While `mdio_oe` is held high, `mdio_o` changes only in the cycle in which MDC falls.
- R7: Busy reads 1 from the cycle after a command write with any operation bit set. It clears only after the last MDC cycle of the frame, and the read data is valid once busy is clear.
- R8: Scan repeatedly reads register 1 of the programmed PHY. Each completed scan read sets link fail to the inverse of data bit 2. Invalid is set by the scan command and clears when the first scan read completes.
- R9: Writing 0 to the command register during a scan lets the current frame finish and apply its result, and no further frame starts. This also holds when the write lands in the cycle in which that frame completes.
- R10: When several operation bits are set, scan takes priority over write, and write takes priority over read.
- R11: The address register reads back only bits 12:8 and 4:0. The write data register reads back all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Two events can fall in the same system cycle: a scan frame's completion and a software write that clears the command. On completion, the block stores the link result and also schedules the next scan frame. The command write has to cancel that new frame without losing the stored result. The bench counts MDC rising edges in its PHY model to find the last bit of a scan frame. It then waits for the following falling edge of MDC and drives the command write so that it is sampled in the completion cycle. It passes if no further frame appears, MDC stays low and link fail holds the value the final frame carried.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W  = 16;
  localparam int DATA_W = 16;
  localparam int PA_W   = 5;

  typedef enum logic [2:0] {
    RA_MODE = 3'd0,
    RA_CMD  = 3'd1,
    RA_ADDR = 3'd2,
    RA_WDAT = 3'd3,
    RA_RDAT = 3'd4,
    RA_STAT = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic              is_read;
    logic [PA_W-1:0]   phy;
    logic [PA_W-1:0]   rga;
    logic [DATA_W-1:0] wd;
  } xfer_t;
endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8,
  localparam int HW   = DIV_W - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          mdc,
  output logic          rise_stb,
  output logic          fall_stb
);
  logic [HW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          hit;

  assign hit      = run && (cnt_q == half - HW'(1));
  assign rise_stb = hit && !mdc_q;
  assign fall_stb = hit && mdc_q;
  assign mdc      = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (hit) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  xfer_t             req,
  input  logic              nopre,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              active,
  output logic              done,
  output logic              mdo,
  output logic              oe,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [5:0] FIRST_TA  = 6'd46;
  localparam logic [5:0] FIRST_DAT = 6'd48;
  localparam logic [5:0] LAST_BIT  = 6'd63;

  logic              act_q, act_d;
  logic              done_q, done_d;
  logic              rd_q, rd_d;
  logic [5:0]        idx_q, idx_d;
  logic [31:0]       fw_q, fw_d;
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    act_d  = act_q;
    done_d = 1'b0;
    rd_d   = rd_q;
    idx_d  = idx_q;
    fw_d   = fw_q;
    sh_d   = sh_q;
    if (start && !act_q) begin
      act_d = 1'b1;
      idx_d = nopre ? 6'd32 : 6'd0;
      rd_d  = req.is_read;
      fw_d  = {2'b01, req.is_read ? 2'b10 : 2'b01, req.phy, req.rga,
               req.is_read ? 2'b00 : 2'b10,
               req.is_read ? {DATA_W{1'b0}} : req.wd};
    end else if (act_q) begin
      if (rise_stb && rd_q && idx_q >= FIRST_DAT)
        sh_d = {sh_q[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        if (idx_q == LAST_BIT) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + 6'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      fw_q   <= '0;
      sh_q   <= '0;
    end else begin
      act_q  <= act_d;
      done_q <= done_d;
      rd_q   <= rd_d;
      idx_q  <= idx_d;
      fw_q   <= fw_d;
      sh_q   <= sh_d;
    end
  end

  assign active = act_q;
  assign done   = done_q;
  assign rdata  = sh_q;
  assign mdo    = act_q ? (idx_q[5] ? fw_q[~idx_q[4:0]] : 1'b1) : 1'b1;
  assign oe     = act_q && !(rd_q && idx_q >= FIRST_TA);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int SCAN_REG = 1,
  parameter int LINK_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam int HW = DIV_W - 1;

  logic              srst_n;
  logic [DIV_W:1]    mode_q, mode_d;
  logic [2:0]        cmd_q, cmd_d;
  logic [PA_W-1:0]   phy_q, phy_d, rga_q, rga_d;
  logic [DATA_W-1:0] wd_q, wd_d, rdat_q, rdat_d;
  logic              lfail_q, lfail_d, inval_q, inval_d;
  logic              pend_q, pend_d, scan_cur_q, scan_cur_d, read_cur_q, read_cur_d;

  logic              eng_start, eng_done, eng_active, rise_stb, fall_stb;
  logic [DATA_W-1:0] eng_rdata;
  logic [HW-1:0]     half;
  logic              wr_cmd, cmd_go, busy;
  xfer_t             req;

  mdio_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign half      = (mode_q[DIV_W-1:1] == '0) ? HW'(1) : mode_q[DIV_W-1:1];
  assign wr_cmd    = reg_wr && (reg_addr == RA_CMD);
  assign cmd_go    = wr_cmd && (reg_wdata[2:0] != 3'b000);
  assign eng_start = pend_q && !eng_active;
  assign busy      = pend_q | eng_active | eng_done;

  always_comb begin
    req.is_read = cmd_q[0] || !cmd_q[2];
    req.phy     = phy_q;
    req.rga     = cmd_q[0] ? PA_W'(SCAN_REG) : rga_q;
    req.wd      = wd_q;
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(srst_n), .run(eng_active), .half(half),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_engine u_eng (
    .clk(clk), .rst_n(srst_n), .start(eng_start), .req(req),
    .nopre(mode_q[DIV_W]), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .mdio_i(mdio_i), .active(eng_active), .done(eng_done),
    .mdo(mdio_o), .oe(mdio_oe), .rdata(eng_rdata)
  );

  always_comb begin
    mode_d = mode_q;   cmd_d = cmd_q;     phy_d = phy_q;   rga_d = rga_q;
    wd_d   = wd_q;     rdat_d = rdat_q;   lfail_d = lfail_q;
    inval_d = inval_q; pend_d = pend_q;
    scan_cur_d = scan_cur_q; read_cur_d = read_cur_q;
    if (eng_start) begin
      pend_d     = 1'b0;
      scan_cur_d = cmd_q[0];
      read_cur_d = req.is_read;
    end
    if (eng_done) begin
      if (read_cur_q) rdat_d = eng_rdata;
      if (scan_cur_q) begin
        lfail_d = ~eng_rdata[LINK_BIT];
        inval_d = 1'b0;
      end
      if (cmd_q[0]) pend_d = 1'b1;
    end
    if (reg_wr) begin
      case (reg_sel_e'(reg_addr))
        RA_MODE: mode_d = reg_wdata[DIV_W:1];
        RA_CMD: begin
          cmd_d  = reg_wdata[2:0];
          pend_d = cmd_go;
          if (reg_wdata[0]) inval_d = 1'b1;
        end
        RA_ADDR: begin
          phy_d = reg_wdata[4:0];
          rga_d = reg_wdata[12:8];
        end
        RA_WDAT: wd_d = reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_q <= '0; cmd_q <= '0; phy_q <= '0; rga_q <= '0;
      wd_q <= '0; rdat_q <= '0; lfail_q <= 1'b0; inval_q <= 1'b0;
      pend_q <= 1'b0; scan_cur_q <= 1'b0; read_cur_q <= 1'b0;
    end else begin
      mode_q <= mode_d; cmd_q <= cmd_d; phy_q <= phy_d; rga_q <= rga_d;
      wd_q <= wd_d; rdat_q <= rdat_d; lfail_q <= lfail_d; inval_q <= inval_d;
      pend_q <= pend_d; scan_cur_q <= scan_cur_d; read_cur_q <= read_cur_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel_e'(reg_addr))
      RA_MODE: reg_rdata = REG_W'({mode_q, 1'b0});
      RA_CMD:  reg_rdata = REG_W'(cmd_q);
      RA_ADDR: reg_rdata = {3'b000, rga_q, 3'b000, phy_q};
      RA_WDAT: reg_rdata = wd_q;
      RA_RDAT: reg_rdata = rdat_q;
      RA_STAT: reg_rdata = REG_W'({inval_q, busy, lfail_q});
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       busy,
  input logic       cmd_go,
  input logic [2:0] cmd_q,
  input logic       eng_start,
  input logic       eng_done,
  input logic       eng_active,
  input logic       inval_q
);
  // R7: an accepted command shows busy on the next cycle
  p_busy_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> busy);

  // R7: completion is reported only once the frame engine is idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> !eng_active);

  // R2: no management clock while not busy
  p_mdc_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R6: driven data moves only with a falling clock
  p_mdo_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mdio_oe) && mdio_oe && !$stable(mdio_o)) |-> $fell(mdc));

  // R8: invalid clears only on a frame completion
  p_inval_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inval_q) |-> $past(eng_done));

  // R9: no frame launches with an empty command
  p_start_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (cmd_q != 3'b000));
endmodule

bind mdio_mgmt_master mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(srst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .cmd_go(cmd_go), .cmd_q(cmd_q), .eng_start(eng_start),
  .eng_done(eng_done), .eng_active(eng_active), .inval_q(inval_q)
);

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  wire  [15:0] reg_rdata;
  wire         mdc, mdio_o, mdio_oe, mdio_i;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  mdio_mgmt_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model
  bit          pre_on = 1;
  logic [15:0] phy_val = 16'h0;
  int          pos = 0;
  int          nfr = 0;
  int          viol = 0;
  longint      cyc = 0, t_last = 0, t_prev = 0;
  logic [63:0] cap_o = '0, cap_oe = '0;
  logic [31:0] fr_o = '0, fr_oe = '0, pre_o = '0;
  logic        prev_mdc = 1'b0, prev_oe = 1'b0, prev_o = 1'b1;

  function automatic logic drv(int p, bit pre, logic [15:0] val);
    int j = p - (pre ? 32 : 0);
    if (j == 15) return 1'b0;
    if (j >= 16 && j <= 31) return val[31-j];
    return 1'b1;
  endfunction

  assign mdio_i = drv(pos, pre_on, phy_val);

  always @(negedge clk) begin
    cyc++;
    if (mdio_oe && !prev_oe && !mdc) pos = 0;
    if (mdc && !prev_mdc) begin
      cap_o  = {cap_o[62:0], mdio_o};
      cap_oe = {cap_oe[62:0], mdio_oe};
      pos++;
      if (pos == (pre_on ? 64 : 32)) begin
        fr_o  = cap_o[31:0];
        fr_oe = cap_oe[31:0];
        pre_o = cap_o[63:32];
        nfr++;
      end
      t_prev = t_last;
      t_last = cyc;
    end
    if (prev_oe && mdio_oe && (mdio_o != prev_o) && !(prev_mdc && !mdc)) viol++;
    prev_mdc = mdc;
    prev_oe  = mdio_oe;
    prev_o   = mdio_o;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [15:0] v;
    bit ok = 0;
    for (int i = 0; i < 20000; i++) begin
      rd_reg(3'd5, v);
      if (!v[1]) begin ok = 1; break; end
    end
    chk({tag, " busy clears"}, 32'(ok), 32'd1);
  endtask

  task automatic wait_frames(input int n);
    for (int i = 0; i < 20000 && nfr < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd_reg(3'd5, v); chk("R1 status", 32'(v), 32'h0);
    rd_reg(3'd4, v); chk("R1 read data", 32'(v), 32'h0);
    rd_reg(3'd0, v); chk("R1 mode", 32'(v), 32'h0);
    rd_reg(3'd1, v); chk("R1 command", 32'(v), 32'h0);
    chk("R1 mdc/oe idle", {30'b0, mdc, mdio_oe}, 32'h0);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr_reg(3'd2, 16'hFFFF); rd_reg(3'd2, v); chk("R11 address fields", 32'(v), 32'h1F1F);
    wr_reg(3'd3, 16'hFFFF); rd_reg(3'd3, v); chk("R11 write data", 32'(v), 32'hFFFF);
    wr_reg(3'd0, 16'h01FF); rd_reg(3'd0, v); chk("R2 divider even", 32'(v), 32'h01FE);
  endtask

  task automatic t_write;
    logic [15:0] v;
    int n0;
    pre_on = 1;
    wr_reg(3'd0, 16'h0004);
    wr_reg(3'd2, {3'b0, 5'h07, 3'b0, 5'h1A});
    wr_reg(3'd3, 16'hBEEF);
    n0 = nfr;
    wr_reg(3'd1, 16'h0004);
    rd_reg(3'd5, v); chk("R7 busy after command", 32'(v[1]), 32'd1);
    wait_idle("R7 write");
    chk("R7 one frame", nfr, n0 + 1);
    chk("R3 write frame", fr_o, {2'b01, 2'b01, 5'h1A, 5'h07, 2'b10, 16'hBEEF});
    chk("R3 preamble", pre_o, 32'hFFFF_FFFF);
    chk("R3 oe whole frame", fr_oe, 32'hFFFF_FFFF);
    chk("R2 mdc low when idle", 32'(mdc), 32'd0);
    wr_reg(3'd1, 16'h0);
  endtask

  task automatic t_read;
    logic [15:0] v;
    pre_on = 1;
    phy_val = 16'h5A3C;
    wr_reg(3'd2, {3'b0, 5'h09, 3'b0, 5'h02});
    wr_reg(3'd1, 16'h0002);
    wait_idle("R4 read");
    rd_reg(3'd4, v); chk("R4 read data", 32'(v), 32'h5A3C);
    chk("R4 read header", 32'(fr_o[31:18]), 32'({2'b01, 2'b10, 5'h02, 5'h09}));
    chk("R4 oe released", fr_oe, 32'hFFFC_0000);
    wr_reg(3'd1, 16'h0);
  endtask

  task automatic t_nopre;
    logic [15:0] v;
    pre_on = 0;
    wr_reg(3'd0, 16'h0104);
    wr_reg(3'd2, {3'b0, 5'h0A, 3'b0, 5'h15});
    wr_reg(3'd3, 16'h0F0F);
    wr_reg(3'd1, 16'h0004);
    wait_idle("R5 write");
    chk("R5 write frame no preamble", fr_o, {2'b01, 2'b01, 5'h15, 5'h0A, 2'b10, 16'h0F0F});
    chk("R5 32 mdc cycles", pos, 32);
    wr_reg(3'd1, 16'h0);
    phy_val = 16'hC3A5;
    wr_reg(3'd1, 16'h0002);
    wait_idle("R5 read");
    rd_reg(3'd4, v); chk("R5 read data no preamble", 32'(v), 32'hC3A5);
    chk("R5 32 mdc cycles read", pos, 32);
    wr_reg(3'd1, 16'h0);
  endtask

  task automatic t_period(input logic [15:0] mode, input int exp);
    pre_on = 0;
    wr_reg(3'd0, mode);
    wr_reg(3'd1, 16'h0002);
    wait_idle("R2 period");
    chk("R2 mdc period", 32'(t_last - t_prev), 32'(exp));
    wr_reg(3'd1, 16'h0);
  endtask

  task automatic t_priority;
    pre_on = 1;
    wr_reg(3'd0, 16'h0004);
    wr_reg(3'd2, {3'b0, 5'h04, 3'b0, 5'h03});
    wr_reg(3'd3, 16'h1234);
    wr_reg(3'd1, 16'h0006);
    wait_idle("R10 write+read");
    chk("R10 write beats read", fr_o, {2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'h1234});
    wr_reg(3'd1, 16'h0);
  endtask

  task automatic t_scan;
    logic [15:0] v;
    int n;
    pre_on = 0;
    phy_val = 16'h0004;
    wr_reg(3'd0, 16'h0104);
    wr_reg(3'd2, {3'b0, 5'h1F, 3'b0, 5'h11});
    n = nfr;
    wr_reg(3'd1, 16'h0003);
    rd_reg(3'd5, v);
    chk("R8 invalid after scan command", 32'(v[2]), 32'd1);
    chk("R8 busy during scan", 32'(v[1]), 32'd1);
    wait_frames(n + 1);
    repeat (8) @(negedge clk);
    rd_reg(3'd5, v);
    chk("R8 invalid cleared, link up", 32'({v[2], v[0]}), 32'd0);
    chk("R10 scan beats read, reg 1", 32'(fr_o[31:18]), 32'({2'b01, 2'b10, 5'h11, 5'h01}));
    rd_reg(3'd4, v); chk("R8 scan read data", 32'(v), 32'h0004);
    phy_val = 16'h0000;
    n = nfr;
    wait_frames(n + 2);
    repeat (8) @(negedge clk);
    rd_reg(3'd5, v); chk("R8 link fail set", 32'(v[0]), 32'd1);
    phy_val = 16'h0004;
    n = nfr;
    wait_frames(n + 1);
    while (mdc) begin @(negedge clk); #1; end
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 16'h0;
    @(negedge clk);
    reg_wr = 1'b0;
    n = nfr;
    wait_idle("R9 stop");
    repeat (300) @(negedge clk);
    chk("R9 no frame after stop", nfr, n);
    chk("R9 mdc low after stop", 32'(mdc), 32'd0);
    rd_reg(3'd5, v); chk("R9 final frame result kept", 32'(v[0]), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_regs;
    t_write;
    t_read;
    t_nopre;
    t_period(16'h0106, 6);
    t_period(16'h0107, 6);
    t_period(16'h0101, 2);
    t_priority;
    t_scan;
    chk("R6 data changes only on falling mdc", viol, 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule